// File: doc/BRIEF.md
# Masked-Write General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port that sits behind a small word-wide register interface with plain read and write strobes. Each pin has a direction bit and an output-data bit. Both are held in flops and drive the output-enable and output-value lines toward the pad ring directly. The pad inputs come back through a two-stage synchroniser before software can read them.

The direction of a pin is never written as a whole word. One strobe register turns the pins under its 1 bits into outputs, and a second one turns them back into inputs. Output data is split into a lower and an upper 16-pin register. Each of those carries a per-pin write mask in its upper half, so driver code can change one pin in a single write and never needs a read-modify-write sequence. A value can be preloaded while the pin is still an input. It then appears at the pad in the cycle the pin becomes an output.

Top module: `gpio_mask_port`

## Requirements
- R1: During and after synchronous reset, `pin_oe`, `pin_out` and `rdata` are all zero.
- R2: A write to byte offset 0x00 sets direction bit n (1 = output) for every 1 in `wdata[n]`. Direction bits under 0s keep their value. The new state is visible on `pin_oe` in the cycle after the write.
- R3: A write to byte offset 0x04 clears direction bit n (pin becomes input) for every 1 in `wdata[n]`. Direction bits under 0s keep their value.
- R4: A write to byte offset 0x08 updates output bit n (n = 0..15) to `wdata[n]` only where mask bit `wdata[16+n]` is 1. Output bits 16..31 and the masked-off bits 0..15 are unchanged.
- R5: A write to byte offset 0x0C updates output bit 16+n (n = 0..15) to `wdata[n]` only where `wdata[16+n]` is 1. Output bits 0..15 and the masked-off upper bits are unchanged.
- R6: A read of byte offset 0x10 returns the pin levels after two synchroniser stages. A level applied to `pin_in` just before clock edge k is returned by a read whose strobe is sampled at edge k+2 or later. A read sampled at edge k or k+1 still returns the previous level.
- R7: `pin_out` follows the output-data state whatever the direction. A value preloaded into an input pin is present on `pin_out` before, during and after the pin is switched to output, and direction writes leave `pin_out` unchanged.
- R8: Reads of offsets 0x00 and 0x04 both return the direction state. Reads of 0x08 and 0x0C return output bits 15..0 and 31..16 respectively in `rdata[15:0]`, with `rdata[31:16]` zero.
- R9: Writes to offset 0x10 or to any unmapped offset change neither `pin_oe` nor `pin_out`. Reads of an unmapped offset return zero.
- R10: `rdata` is loaded in the cycle after a cycle with `rd_en` high, and it holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one register write per cycle it is high |
| rd_en | input | 1 | Read strobe, loads `rdata` at the next edge |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous levels from the pads |
| pin_oe | output | 32 | Per-pin output enable, 1 = drive |
| pin_out | output | 32 | Per-pin output value |

## Verification
The properties assume that `wr_en` and `rd_en` are sampled only at rising edges and that `addr` and `wdata` are stable whenever a strobe is high. They also assume that `pin_in` is a clean level for the synchroniser check, because that check compares the read value with the input sampled three edges earlier. The bench drives every input at the falling edge, so each strobe, address and pin level is settled a half period before the edge that uses it. Pin levels change only when no read of them overlaps the change. The read-timing assertion is only armed once two reset-free edges have filled the synchroniser.

// File: rtl/gpio_mask_pkg.sv
`timescale 1ns/1ps
package gpio_mask_pkg;

  // Byte offsets of the register window; software depends on these.
  localparam int unsigned OFF_MK_OUT  = 'h00;
  localparam int unsigned OFF_MK_IN   = 'h04;
  localparam int unsigned OFF_DATA_LO = 'h08;
  localparam int unsigned OFF_DATA_HI = 'h0C;
  localparam int unsigned OFF_LEVEL   = 'h10;

  typedef enum logic [2:0] {
    SEL_MK_OUT,
    SEL_MK_IN,
    SEL_DATA_LO,
    SEL_DATA_HI,
    SEL_LEVEL,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/gpio_mask_decode.sv
`timescale 1ns/1ps
module gpio_mask_decode
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  always_comb begin
    if (addr == ADDR_W'(OFF_MK_OUT))       sel = SEL_MK_OUT;
    else if (addr == ADDR_W'(OFF_MK_IN))   sel = SEL_MK_IN;
    else if (addr == ADDR_W'(OFF_DATA_LO)) sel = SEL_DATA_LO;
    else if (addr == ADDR_W'(OFF_DATA_HI)) sel = SEL_DATA_HI;
    else if (addr == ADDR_W'(OFF_LEVEL))   sel = SEL_LEVEL;
    else                                   sel = SEL_NONE;
  end

endmodule

// File: rtl/gpio_mask_sync.sv
`timescale 1ns/1ps
module gpio_mask_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/gpio_mask_state.sv
`timescale 1ns/1ps
module gpio_mask_state
  import gpio_mask_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] out_q
);

  localparam int HALF = DATA_W / 2;

  logic [HALF-1:0] wr_mask;
  logic [HALF-1:0] wr_val;
  assign wr_mask = wdata[DATA_W-1:HALF];
  assign wr_val  = wdata[HALF-1:0];

  // Direction: separate set and clear strobes, never a whole-word write.
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_MK_OUT)      dir_q <= dir_q | wdata;
      else if (sel == SEL_MK_IN)  dir_q <= dir_q & ~wdata;
    end
  end

  // Output data: one masked register per half of the port.
  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      localparam reg_sel_e HSEL = (h == 0) ? SEL_DATA_LO : SEL_DATA_HI;
      always_ff @(posedge clk) begin
        if (rst) begin
          out_q[h*HALF +: HALF] <= '0;
        end else if (wr_en && sel == HSEL) begin
          out_q[h*HALF +: HALF] <= (out_q[h*HALF +: HALF] & ~wr_mask)
                                 | (wr_val & wr_mask);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_mask_port.sv
`timescale 1ns/1ps
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_oe,
  output logic [DATA_W-1:0] pin_out
);

  localparam int HALF = DATA_W / 2;

  reg_sel_e          sel;
  logic [DATA_W-1:0] dir_q;
  logic [DATA_W-1:0] out_q;
  logic [DATA_W-1:0] level_q;

  gpio_mask_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .sel  (sel)
  );

  gpio_mask_state #(.DATA_W(DATA_W)) u_state (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .sel   (sel),
    .wdata (wdata),
    .dir_q (dir_q),
    .out_q (out_q)
  );

  gpio_mask_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (level_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_MK_OUT,
        SEL_MK_IN:   rdata <= dir_q;
        SEL_DATA_LO: rdata <= {{HALF{1'b0}}, out_q[HALF-1:0]};
        SEL_DATA_HI: rdata <= {{HALF{1'b0}}, out_q[DATA_W-1:HALF]};
        SEL_LEVEL:   rdata <= level_q;
        default:     rdata <= '0;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;

endmodule

// File: rtl/gpio_mask_port_chk.sv
`timescale 1ns/1ps
module gpio_mask_port_chk
  import gpio_mask_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] pin_in,
  input logic [DATA_W-1:0] pin_oe,
  input logic [DATA_W-1:0] pin_out
);

  localparam int HALF = DATA_W / 2;

  logic a_mk_out, a_mk_in, a_lo, a_hi, a_lvl;
  assign a_mk_out = (addr == ADDR_W'(OFF_MK_OUT));
  assign a_mk_in  = (addr == ADDR_W'(OFF_MK_IN));
  assign a_lo     = (addr == ADDR_W'(OFF_DATA_LO));
  assign a_hi     = (addr == ADDR_W'(OFF_DATA_HI));
  assign a_lvl    = (addr == ADDR_W'(OFF_LEVEL));

  // Edges seen since reset was released, saturating.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && rdata == '0));

  p_dir_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a_mk_out) |=> pin_oe == ($past(pin_oe) | $past(wdata)));

  p_dir_clr_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a_mk_in) |=> pin_oe == ($past(pin_oe) & ~$past(wdata)));

  p_lo_upper_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a_lo) |=> ($stable(pin_out[DATA_W-1:HALF]) && $stable(pin_oe)));

  p_lo_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a_lo) |=>
      ((pin_out[HALF-1:0] ^ $past(wdata[HALF-1:0])) & $past(wdata[DATA_W-1:HALF])) == '0);

  p_hi_lower_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a_hi) |=> ($stable(pin_out[HALF-1:0]) && $stable(pin_oe)));

  p_hi_masked_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && a_hi) |=>
      ((pin_out[DATA_W-1:HALF] ^ $past(wdata[HALF-1:0])) & $past(wdata[DATA_W-1:HALF])) == '0);

  p_sync_delay_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && rd_en && a_lvl) |=> rdata == $past(pin_in, 3));

  p_dir_keeps_out_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (a_mk_out || a_mk_in)) |=> $stable(pin_out));

  p_dead_write_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !a_mk_out && !a_mk_in && !a_lo && !a_hi) |=>
      ($stable(pin_oe) && $stable(pin_out)));

  p_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(pin_oe) && $stable(pin_out)));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

bind gpio_mask_port gpio_mask_port_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .pin_in  (pin_in),
  .pin_oe  (pin_oe),
  .pin_out (pin_out)
);

// File: tb/test_gpio_mask_port.sv
`timescale 1ns/1ps
module test_gpio_mask_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_oe;
  logic [31:0] pin_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_oe  = '0;
  logic [31:0] exp_out = '0;

  always #10 clk = ~clk;

  gpio_mask_port i_gpio_mask_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks are entered at a falling edge and leave at a falling edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // Bench model of the register rules.
  task automatic model_data(input bit hi, input logic [31:0] d);
    for (int i = 0; i < 16; i++)
      if (d[16+i]) exp_out[(hi ? 16 : 0) + i] = d[i];
  endtask

  task automatic t_reset();
    check("R1 oe", pin_oe, '0);
    check("R1 out", pin_out, '0);
    check("R1 rdata", rdata, '0);
  endtask

  task automatic t_dir_set();
    logic [31:0] d;
    wr(5'h00, 32'h0000_00F0); exp_oe |= 32'h0000_00F0;
    check("R2 first set", pin_oe, exp_oe);
    wr(5'h00, 32'h8000_0011); exp_oe |= 32'h8000_0011;
    check("R2 zeros keep", pin_oe, exp_oe);
    rd(5'h00, d); check("R8 read 0x00", d, exp_oe);
  endtask

  task automatic t_dir_clr();
    logic [31:0] d;
    wr(5'h04, 32'h0000_0030); exp_oe &= ~32'h0000_0030;
    check("R3 clear", pin_oe, exp_oe);
    rd(5'h04, d); check("R8 read 0x04", d, exp_oe);
  endtask

  task automatic t_data_lo();
    logic [31:0] d;
    wr(5'h08, 32'h00FF_FFFF); model_data(1'b0, 32'h00FF_FFFF);
    check("R4 low masked", pin_out, exp_out);
    wr(5'h08, 32'h0005_0000); model_data(1'b0, 32'h0005_0000);
    check("R4 single pins to 0", pin_out, exp_out);
    rd(5'h08, d); check("R8 read 0x08", d, {16'h0, exp_out[15:0]});
  endtask

  task automatic t_data_hi();
    logic [31:0] d;
    wr(5'h0C, 32'hF00F_ABCD); model_data(1'b1, 32'hF00F_ABCD);
    check("R5 high masked", pin_out, exp_out);
    wr(5'h0C, 32'h0000_FFFF); model_data(1'b1, 32'h0000_FFFF);
    check("R5 empty mask", pin_out, exp_out);
    rd(5'h0C, d); check("R8 read 0x0C", d, {16'h0, exp_out[31:16]});
  endtask

  task automatic t_preload();
    // Pin 20 is an input; preload 1, then turn it into an output.
    check("R7 pin20 input", {31'h0, pin_oe[20]}, 32'h0);
    wr(5'h0C, 32'h0010_0010); model_data(1'b1, 32'h0010_0010);
    check("R7 preload visible", pin_out, exp_out);
    wr(5'h00, 32'h0010_0000); exp_oe |= 32'h0010_0000;
    check("R7 oe now on", pin_oe, exp_oe);
    check("R7 value kept", pin_out, exp_out);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    pin_in = 32'hA5A5_5A5A;
    rd(5'h10, d); check("R6 edge k old", d, 32'h0);
    rd(5'h10, d); check("R6 edge k+1 old", d, 32'h0);
    rd(5'h10, d); check("R6 edge k+2 new", d, 32'hA5A5_5A5A);
    pin_in = 32'h0000_0001;
    @(negedge clk); @(negedge clk);
    rd(5'h10, d); check("R6 second pattern", d, 32'h0000_0001);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(5'h10, 32'hFFFF_FFFF);
    check("R9 level write oe", pin_oe, exp_oe);
    check("R9 level write out", pin_out, exp_out);
    wr(5'h14, 32'hFFFF_FFFF);
    check("R9 unmapped write oe", pin_oe, exp_oe);
    check("R9 unmapped write out", pin_out, exp_out);
    wr(5'h09, 32'hFFFF_FFFF);
    check("R9 misaligned write out", pin_out, exp_out);
    rd(5'h1C, d); check("R9 unmapped read", d, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    rd(5'h00, d);
    wr(5'h00, 32'h0000_0F00); exp_oe |= 32'h0000_0F00;
    addr = 5'h08;
    @(negedge clk); @(negedge clk);
    check("R10 rdata held", rdata, d);
    rd(5'h00, d); check("R10 reload", d, exp_oe);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dir_set();
    t_dir_clr();
    t_data_lo();
    t_data_hi();
    t_preload();
    t_sync();
    t_unmapped();
    t_hold();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule